// File: doc/BRIEF.md
# Script Engine Local Memory with Access Router

This block holds a 2048-word by 32-bit memory (8 KB) next to a script engine. The memory occupies an 8 KB window whose 64-bit base can be moved anywhere in the address space. Every engine access is steered by its address and its kind. Instruction fetches, table-indirect fetches and load/store accesses that land in the window are served locally, and the system bus never sees them. Any other engine access goes to the external bus-master request interface, even one aimed at the window. So does any access that misses the window, and every access while the memory is switched off.

A host reaches the same memory through a slave port. That port works on whole words and writes individual bytes under per-byte enables. The port also paces accesses to ordinary registers, so that both kinds of target finish after a fixed number of wait states. A memory access is shorter than a register access. The base address is written as two 32-bit halves. The low half can be mirrored onto the scratch read path so that loader software can find it. The high half is always readable on a separate path.

Top module: `script_mem_top`

## Requirements
- R1: The memory holds 2048 words of 32 bits. A host write to any word index from 0 to 2047 reads back unchanged through the host port.
- R2: An engine access of kind 2'b00 (instruction fetch) or 2'b01 (table-indirect fetch) that hits the window keeps `ext_req` low. It returns `eng_ack` with the word in the cycle after the request.
- R3: An engine access of kind 2'b10 (load/store) that hits the window is served locally and keeps `ext_req` low. This holds for reads and for byte-enabled writes.
- R4: An engine access of kind 2'b11 (any other access) is forwarded with `ext_req` high even when it hits the window. Its address, data and kind are passed through, and `eng_ack`/`eng_rdata` come from the external side in the same cycle.
- R5: The window is hit only when `eng_addr[63:13]` equals base bits [63:13]. The word index is `eng_addr[12:2]`. A miss is forwarded externally.
- R6: The enable resets to 1. While it is 0, no access hits the window and every engine access is forwarded externally.
- R7: The base register resets to zero and is written as a low half and a high half. Bits [12:0] always read as zero.
- R8: With `mirror_sel` high, `scratch_rdata` returns base bits [31:0]. Otherwise it returns `scratch_in`. `fetch_sel_rdata` always returns base bits [63:32].
- R9: A host write changes only the bytes whose `hst_be` bit is set. Bit n enables bits [8n+7:8n].
- R10: A host memory access (`hst_ram`=1) with no contention raises `hst_done` for one cycle, 3 wait cycles after the request cycle, that is 4 cycles after it.
- R11: A host register access (`hst_ram`=0) raises `hst_done` 5 wait cycles after the request cycle, that is 6 cycles after it.
- R12: If a local engine access falls in the host's memory access cycle, the engine is served first and the host finishes one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng_req | input | 1 | Engine request, held until `eng_ack` |
| eng_kind | input | 2 | Access kind: 00 fetch, 01 table-indirect, 10 load/store, 11 other |
| eng_we | input | 1 | Engine write |
| eng_addr | input | 64 | Engine byte address |
| eng_be | input | 4 | Engine byte enables |
| eng_wdata | input | 32 | Engine write data |
| eng_ack | output | 1 | Engine access complete |
| eng_rdata | output | 32 | Engine read data, valid with `eng_ack` |
| ext_req | output | 1 | Forwarded request to the bus master |
| ext_kind | output | 2 | Forwarded kind |
| ext_we | output | 1 | Forwarded write |
| ext_addr | output | 64 | Forwarded address |
| ext_be | output | 4 | Forwarded byte enables |
| ext_wdata | output | 32 | Forwarded write data |
| ext_ack | input | 1 | Bus master completion |
| ext_rdata | input | 32 | Bus master read data |
| hst_sel | input | 1 | One-cycle host access start |
| hst_ram | input | 1 | 1: memory target, 0: ordinary register |
| hst_we | input | 1 | Host write |
| hst_word | input | 11 | Host word index |
| hst_be | input | 4 | Host byte enables |
| hst_wdata | input | 32 | Host write data |
| hst_done | output | 1 | Host access complete, one cycle |
| hst_rdata | output | 32 | Host read data for memory targets, valid with `hst_done` |
| base_wr_lo | input | 1 | Write base bits [31:0] |
| base_wr_hi | input | 1 | Write base bits [63:32] |
| base_wdata | input | 32 | Base write value |
| en_wr | input | 1 | Write the enable |
| en_wdata | input | 1 | Enable value |
| mirror_sel | input | 1 | Mirror base low half on the scratch path |
| scratch_in | input | 32 | Normal scratch register content |
| ram_en | output | 1 | Current enable |
| scratch_rdata | output | 32 | Scratch read path |
| fetch_sel_rdata | output | 32 | Base bits [63:32] |

## Verification
The assertions assume that the engine holds `eng_req`, with its kind and address unchanged, until `eng_ack`. They assume the external side acknowledges only while `ext_req` is high, and that `hst_sel` comes only when no host access is pending. The directed tasks keep to these rules. Each engine operation holds its request up to the acknowledge and then drops it. The modelled bus master acknowledges exactly when asked. Host operations are issued one at a time and each waits for `hst_done`. The contention scenario places an engine fetch in the host's access cycle on purpose.

// File: rtl/smem_pkg.sv
// Package: shared access-kind encoding and routing helper for the script memory.
// Assumes a two-bit kind field driven by the script engine.
package smem_pkg;

    typedef enum logic [1:0] {
        K_INSTR = 2'b00,
        K_TABLE = 2'b01,
        K_LDST  = 2'b10,
        K_OTHER = 2'b11
    } eng_kind_e;

    // True for kinds that may be served by the local memory.
    function automatic logic kind_stays_local(input logic [1:0] k);
        return k != K_OTHER;
    endfunction

endpackage

// File: rtl/smem_cfg_regs.sv
// Module: holds the relocatable base and the enable, and drives the
// readback paths (scratch mirror and high-half selector).
// Assumes ADDR_W is twice HALF_W; base stays aligned to the window size.
module smem_cfg_regs #(
    parameter int ADDR_W  = 64,
    parameter int HALF_W  = 32,
    parameter int WIN_LSB = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_lo,
    input  logic              base_wr_hi,
    input  logic [HALF_W-1:0] base_wdata,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              mirror_sel,
    input  logic [HALF_W-1:0] scratch_in,
    output logic [ADDR_W-1:0] base,
    output logic              ram_en,
    output logic [HALF_W-1:0] scratch_rdata,
    output logic [HALF_W-1:0] fetch_sel_rdata
);
    localparam logic [HALF_W-1:0] ALIGN_MASK = ~((HALF_W'(1) << WIN_LSB) - HALF_W'(1));

    logic [HALF_W-1:0] base_lo_q;
    logic [HALF_W-1:0] base_hi_q;
    logic              en_q;

    // Base halves and enable; enable comes out of reset set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            en_q      <= 1'b1;
        end else begin
            if (base_wr_lo) base_lo_q <= base_wdata & ALIGN_MASK;
            if (base_wr_hi) base_hi_q <= base_wdata;
            if (en_wr)      en_q      <= en_wdata;
        end
    end

    // Readback paths.
    always_comb begin
        base            = {base_hi_q, base_lo_q};
        ram_en          = en_q;
        scratch_rdata   = mirror_sel ? base_lo_q : scratch_in;
        fetch_sel_rdata = base_hi_q;
    end

endmodule

// File: rtl/smem_router.sv
// Module: decides per engine access between the local memory and the
// external bus master, and returns acknowledge and data to the engine.
// Assumes the engine holds its request stable until it sees eng_ack.
module smem_router #(
    parameter int ADDR_W  = 64,
    parameter int DATA_W  = 32,
    parameter int WIN_LSB = 13,
    parameter int BYTE_OFF = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                eng_req,
    input  logic [1:0]          eng_kind,
    input  logic                eng_we,
    input  logic [ADDR_W-1:0]   eng_addr,
    input  logic [DATA_W/8-1:0] eng_be,
    input  logic [DATA_W-1:0]   eng_wdata,
    output logic                eng_ack,
    output logic [DATA_W-1:0]   eng_rdata,
    input  logic [ADDR_W-1:0]   base,
    input  logic                ram_en,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic                int_go,
    output logic                int_ack_q,
    output logic                ext_req,
    output logic [1:0]          ext_kind,
    output logic                ext_we,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic [DATA_W/8-1:0] ext_be,
    output logic [DATA_W-1:0]   ext_wdata,
    input  logic                ext_ack,
    input  logic [DATA_W-1:0]   ext_rdata
);
    import smem_pkg::*;

    logic hit;
    logic stay_local;
    logic unused_lane_bits;

    // Window match and local decision.
    always_comb begin
        hit        = ram_en && (eng_addr[ADDR_W-1:WIN_LSB] == base[ADDR_W-1:WIN_LSB]);
        stay_local = hit && kind_stays_local(eng_kind);
        int_go     = eng_req && stay_local && !int_ack_q;
        ext_req    = eng_req && !stay_local && !int_ack_q;
    end

    assign unused_lane_bits = ^eng_addr[BYTE_OFF-1:0];

    // Local accesses complete one cycle after issue.
    always_ff @(posedge clk) begin
        if (!rst_n) int_ack_q <= 1'b0;
        else        int_ack_q <= int_go;
    end

    // Pass-through to the bus master and return mux to the engine.
    always_comb begin
        ext_kind  = eng_kind;
        ext_we    = eng_we;
        ext_addr  = eng_addr;
        ext_be    = eng_be;
        ext_wdata = eng_wdata;
        eng_ack   = int_ack_q || (ext_req && ext_ack);
        eng_rdata = int_ack_q ? ram_rdata : ext_rdata;
    end

endmodule

// File: rtl/smem_host_port.sv
// Module: host slave sequencer. Counts a fixed number of wait cycles per
// target kind and yields its memory slot to a concurrent engine access.
// Assumes hst_sel is pulsed only while no access is pending.
module smem_host_port #(
    parameter int DATA_W   = 32,
    parameter int WORD_AW  = 11,
    parameter int RAM_WAIT = 3,
    parameter int REG_WAIT = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hst_sel,
    input  logic                hst_ram,
    input  logic                hst_we,
    input  logic [WORD_AW-1:0]  hst_word,
    input  logic [DATA_W/8-1:0] hst_be,
    input  logic [DATA_W-1:0]   hst_wdata,
    input  logic                eng_int_go,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic                host_go,
    output logic                host_we,
    output logic [WORD_AW-1:0]  host_word,
    output logic [DATA_W/8-1:0] host_be,
    output logic [DATA_W-1:0]   host_wdata,
    output logic                busy_q,
    output logic                is_ram_q,
    output logic                hst_done,
    output logic [DATA_W-1:0]   hst_rdata
);
    localparam int CNT_W = $clog2(REG_WAIT + 1) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             start;
    logic             slot;
    logic             stall;

    // Slot and stall decode.
    always_comb begin
        start   = hst_sel && !busy_q;
        slot    = busy_q && (cnt_q == CNT_W'(1));
        stall   = slot && is_ram_q && eng_int_go;
        host_go = slot && is_ram_q && !eng_int_go;
    end

    // Wait-state counter and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            is_ram_q   <= 1'b0;
            cnt_q      <= '0;
            done_q     <= 1'b0;
            host_we    <= 1'b0;
            host_word  <= '0;
            host_be    <= '0;
            host_wdata <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q     <= 1'b1;
                is_ram_q   <= hst_ram;
                cnt_q      <= hst_ram ? CNT_W'(RAM_WAIT) : CNT_W'(REG_WAIT);
                host_we    <= hst_we;
                host_word  <= hst_word;
                host_be    <= hst_be;
                host_wdata <= hst_wdata;
            end else if (busy_q) begin
                if (slot) begin
                    if (!stall) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    // Completion outputs.
    always_comb begin
        hst_done  = done_q;
        hst_rdata = (done_q && is_ram_q) ? ram_rdata : '0;
    end

endmodule

// File: rtl/smem_array.sv
// Module: single-port word memory with byte-lane writes and a registered
// read word; the engine side wins when both sides ask in one cycle.
// Assumes the host side only asks in cycles the engine does not.
module smem_array #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 2048,
    parameter int WORD_AW = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_go,
    input  logic                a_we,
    input  logic [WORD_AW-1:0]  a_word,
    input  logic [DATA_W/8-1:0] a_be,
    input  logic [DATA_W-1:0]   a_wdata,
    input  logic                b_go,
    input  logic                b_we,
    input  logic [WORD_AW-1:0]  b_word,
    input  logic [DATA_W/8-1:0] b_be,
    input  logic [DATA_W-1:0]   b_wdata,
    output logic [DATA_W-1:0]   rdata
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0]  mem [DEPTH];
    logic               acc;
    logic               we;
    logic [WORD_AW-1:0] idx;
    logic [LANES-1:0]   be;
    logic [DATA_W-1:0]  wd;

    // Port selection with engine priority.
    always_comb begin
        acc = a_go || b_go;
        we  = a_go ? a_we    : b_we;
        idx = a_go ? a_word  : b_word;
        be  = a_go ? a_be    : b_be;
        wd  = a_go ? a_wdata : b_wdata;
    end

    // Byte-lane writes into the storage.
    always_ff @(posedge clk) begin
        if (acc && we) begin
            for (int b = 0; b < LANES; b++) begin
                if (be[b]) mem[idx][b*8 +: 8] <= wd[b*8 +: 8];
            end
        end
    end

    // Registered read word.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= '0;
        else if (acc && !we) rdata <= mem[idx];
    end

endmodule

// File: rtl/script_mem_top.sv
// Module: top of the script memory block. Joins configuration, engine
// router, host sequencer and storage.
// Assumes a single clock domain and synchronous active-low reset.
module script_mem_top #(
    parameter int ADDR_W   = 64,
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 2048,
    parameter int RAM_WAIT = 3,
    parameter int REG_WAIT = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                eng_req,
    input  logic [1:0]          eng_kind,
    input  logic                eng_we,
    input  logic [ADDR_W-1:0]   eng_addr,
    input  logic [DATA_W/8-1:0] eng_be,
    input  logic [DATA_W-1:0]   eng_wdata,
    output logic                eng_ack,
    output logic [DATA_W-1:0]   eng_rdata,
    output logic                ext_req,
    output logic [1:0]          ext_kind,
    output logic                ext_we,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic [DATA_W/8-1:0] ext_be,
    output logic [DATA_W-1:0]   ext_wdata,
    input  logic                ext_ack,
    input  logic [DATA_W-1:0]   ext_rdata,
    input  logic                hst_sel,
    input  logic                hst_ram,
    input  logic                hst_we,
    input  logic [$clog2(DEPTH)-1:0] hst_word,
    input  logic [DATA_W/8-1:0] hst_be,
    input  logic [DATA_W-1:0]   hst_wdata,
    output logic                hst_done,
    output logic [DATA_W-1:0]   hst_rdata,
    input  logic                base_wr_lo,
    input  logic                base_wr_hi,
    input  logic [ADDR_W/2-1:0] base_wdata,
    input  logic                en_wr,
    input  logic                en_wdata,
    input  logic                mirror_sel,
    input  logic [ADDR_W/2-1:0] scratch_in,
    output logic                ram_en,
    output logic [ADDR_W/2-1:0] scratch_rdata,
    output logic [ADDR_W/2-1:0] fetch_sel_rdata
);
    localparam int WORD_AW  = $clog2(DEPTH);
    localparam int BYTE_OFF = $clog2(DATA_W / 8);
    localparam int WIN_LSB  = WORD_AW + BYTE_OFF;
    localparam int HALF_W   = ADDR_W / 2;

    logic [ADDR_W-1:0]   base;
    logic [DATA_W-1:0]   ram_rdata;
    logic                int_go;
    logic                int_ack_q;
    logic                host_go;
    logic                host_we;
    logic [WORD_AW-1:0]  host_word;
    logic [DATA_W/8-1:0] host_be;
    logic [DATA_W-1:0]   host_wdata;
    logic                host_busy;
    logic                host_is_ram;

    smem_cfg_regs #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .WIN_LSB(WIN_LSB)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .base_wr_lo(base_wr_lo), .base_wr_hi(base_wr_hi), .base_wdata(base_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .mirror_sel(mirror_sel), .scratch_in(scratch_in),
        .base(base), .ram_en(ram_en),
        .scratch_rdata(scratch_rdata), .fetch_sel_rdata(fetch_sel_rdata)
    );

    smem_router #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LSB(WIN_LSB), .BYTE_OFF(BYTE_OFF)) u_rtr (
        .clk(clk), .rst_n(rst_n),
        .eng_req(eng_req), .eng_kind(eng_kind), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_be(eng_be), .eng_wdata(eng_wdata), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .base(base), .ram_en(ram_en), .ram_rdata(ram_rdata),
        .int_go(int_go), .int_ack_q(int_ack_q),
        .ext_req(ext_req), .ext_kind(ext_kind), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_be(ext_be), .ext_wdata(ext_wdata), .ext_ack(ext_ack), .ext_rdata(ext_rdata)
    );

    smem_host_port #(.DATA_W(DATA_W), .WORD_AW(WORD_AW),
                     .RAM_WAIT(RAM_WAIT), .REG_WAIT(REG_WAIT)) u_host (
        .clk(clk), .rst_n(rst_n),
        .hst_sel(hst_sel), .hst_ram(hst_ram), .hst_we(hst_we), .hst_word(hst_word),
        .hst_be(hst_be), .hst_wdata(hst_wdata),
        .eng_int_go(int_go), .ram_rdata(ram_rdata),
        .host_go(host_go), .host_we(host_we), .host_word(host_word),
        .host_be(host_be), .host_wdata(host_wdata),
        .busy_q(host_busy), .is_ram_q(host_is_ram),
        .hst_done(hst_done), .hst_rdata(hst_rdata)
    );

    smem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .WORD_AW(WORD_AW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .a_go(int_go), .a_we(eng_we), .a_word(eng_addr[WIN_LSB-1:BYTE_OFF]),
        .a_be(eng_be), .a_wdata(eng_wdata),
        .b_go(host_go), .b_we(host_we), .b_word(host_word),
        .b_be(host_be), .b_wdata(host_wdata),
        .rdata(ram_rdata)
    );

endmodule

// File: rtl/smem_checker.sv
// Module: property checker for script_mem_top, attached by bind.
// Assumes the engine holds its request until acknowledged and the host
// pulses hst_sel only when idle.
module smem_checker #(
    parameter int ADDR_W   = 64,
    parameter int WIN_LSB  = 13,
    parameter int RAM_WAIT = 3,
    parameter int REG_WAIT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eng_req,
    input logic [1:0]        eng_kind,
    input logic [ADDR_W-1:0] eng_addr,
    input logic [ADDR_W-1:0] base,
    input logic              ram_en,
    input logic              ext_req,
    input logic              eng_ack,
    input logic              int_go,
    input logic              int_ack_q,
    input logic              host_go,
    input logic              host_busy,
    input logic              host_is_ram,
    input logic              hst_sel,
    input logic              hst_done
);
    localparam int WC_W = 8;

    logic            in_win;
    logic [WC_W-1:0] wait_cnt;

    assign in_win = eng_addr[ADDR_W-1:WIN_LSB] == base[ADDR_W-1:WIN_LSB];

    // Counts busy cycles of the current host access.
    always_ff @(posedge clk) begin
        if (!rst_n)                      wait_cnt <= '0;
        else if (hst_sel && !host_busy)  wait_cnt <= '0;
        else if (host_busy && wait_cnt != {WC_W{1'b1}}) wait_cnt <= wait_cnt + WC_W'(1);
    end

    p_local_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && ram_en && in_win && eng_kind != 2'b11) |-> !ext_req);

    p_local_ack_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_go |=> eng_ack);

    p_other_goes_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_kind == 2'b11) |-> ext_req);

    p_miss_goes_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !int_ack_q && !in_win) |-> ext_req);

    p_disabled_goes_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !int_ack_q && !ram_en) |-> (ext_req && !int_go));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hst_done |=> !hst_done);

    p_ram_min_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_done && host_is_ram) |-> wait_cnt >= WC_W'(RAM_WAIT));

    p_reg_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_done && !host_is_ram) |-> wait_cnt == WC_W'(REG_WAIT));

    p_engine_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_go && host_go));

endmodule

bind script_mem_top smem_checker #(
    .ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .RAM_WAIT(RAM_WAIT), .REG_WAIT(REG_WAIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_kind(eng_kind),
    .eng_addr(eng_addr), .base(base), .ram_en(ram_en), .ext_req(ext_req),
    .eng_ack(eng_ack), .int_go(int_go), .int_ack_q(int_ack_q),
    .host_go(host_go), .host_busy(host_busy), .host_is_ram(host_is_ram),
    .hst_sel(hst_sel), .hst_done(hst_done)
);

// File: tb/sim_script_mem_top.sv
// Directed bench for script_mem_top: one task per scenario.
module sim_script_mem_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eng_req = 1'b0;
    logic [1:0]  eng_kind = 2'b00;
    logic        eng_we = 1'b0;
    logic [63:0] eng_addr = '0;
    logic [3:0]  eng_be = 4'hF;
    logic [31:0] eng_wdata = '0;
    logic        eng_ack;
    logic [31:0] eng_rdata;
    logic        ext_req;
    logic [1:0]  ext_kind;
    logic        ext_we;
    logic [63:0] ext_addr;
    logic [3:0]  ext_be;
    logic [31:0] ext_wdata;
    logic        ext_ack;
    logic [31:0] ext_rdata;
    logic        hst_sel = 1'b0;
    logic        hst_ram = 1'b0;
    logic        hst_we = 1'b0;
    logic [10:0] hst_word = '0;
    logic [3:0]  hst_be = 4'hF;
    logic [31:0] hst_wdata = '0;
    logic        hst_done;
    logic [31:0] hst_rdata;
    logic        base_wr_lo = 1'b0;
    logic        base_wr_hi = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        en_wr = 1'b0;
    logic        en_wdata = 1'b0;
    logic        mirror_sel = 1'b0;
    logic [31:0] scratch_in = 32'hCAFE_F00D;
    logic        ram_en;
    logic [31:0] scratch_rdata;
    logic [31:0] fetch_sel_rdata;

    localparam logic [63:0] BASE = 64'h0000_0001_8000_2000;

    int checks = 0;
    int errors = 0;
    logic [63:0] ext_addr_seen;

    always #10 clk = ~clk;

    // Bus master model: acknowledges at once, data derived from address.
    assign ext_ack   = ext_req;
    assign ext_rdata = ext_addr[31:0] ^ 32'hA5A5_A5A5;

    script_mem_top u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic eng_op(input logic [1:0] k, input logic we, input logic [63:0] a,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic ext_seen, output int lat);
        @(negedge clk);
        eng_req = 1'b1; eng_kind = k; eng_we = we; eng_addr = a; eng_wdata = wd; eng_be = 4'hF;
        #1;
        ext_seen = ext_req;
        ext_addr_seen = ext_addr;
        lat = 0;
        while (!eng_ack && lat < 20) begin
            @(negedge clk); #1; lat++;
        end
        rd = eng_rdata;
        eng_req = 1'b0; eng_we = 1'b0;
    endtask

    task automatic host_op(input logic ram, input logic we, input logic [10:0] w,
                           input logic [3:0] be, input logic [31:0] wd,
                           output logic [31:0] rd, output int n);
        @(negedge clk);
        hst_sel = 1'b1; hst_ram = ram; hst_we = we; hst_word = w; hst_be = be; hst_wdata = wd;
        @(negedge clk);
        hst_sel = 1'b0;
        n = 1;
        #1;
        while (!hst_done && n < 30) begin
            @(negedge clk); #1; n++;
        end
        rd = hst_rdata;
    endtask

    task automatic t_reset;
        mirror_sel = 1'b1;
        #1;
        chk("R6 enable after reset", ram_en, 1);
        chk("R7 base low after reset", scratch_rdata, 0);
        chk("R7 base high after reset", fetch_sel_rdata, 0);
        chk("R2 no external request after reset", ext_req, 0);
        chk("R10 no done after reset", hst_done, 0);
    endtask

    task automatic t_base;
        @(negedge clk);
        base_wr_lo = 1'b1; base_wr_hi = 1'b0; base_wdata = 32'h8000_2345;
        @(negedge clk);
        base_wr_lo = 1'b0; base_wr_hi = 1'b1; base_wdata = BASE[63:32];
        @(negedge clk);
        base_wr_hi = 1'b0;
        mirror_sel = 1'b1;
        #1;
        chk("R7 low bits cleared in mirror", scratch_rdata, BASE[31:0]);
        chk("R8 high half readback", fetch_sel_rdata, BASE[63:32]);
        mirror_sel = 1'b0;
        #1;
        chk("R8 scratch path without mirror", scratch_rdata, 32'hCAFE_F00D);
    endtask

    task automatic t_host;
        logic [31:0] rd;
        int n;
        host_op(1'b1, 1'b1, 11'd5, 4'hF, 32'h1122_3344, rd, n);
        chk("R10 memory write wait count", n, 4);
        host_op(1'b1, 1'b1, 11'd5, 4'b0010, 32'hAABB_CCDD, rd, n);
        host_op(1'b1, 1'b0, 11'd5, 4'hF, 32'h0, rd, n);
        chk("R9 byte lane write", rd, 32'h1122_CC44);
        chk("R10 memory read wait count", n, 4);
        host_op(1'b1, 1'b1, 11'd2047, 4'hF, 32'hFEED_BEEF, rd, n);
        host_op(1'b1, 1'b0, 11'd2047, 4'hF, 32'h0, rd, n);
        chk("R1 last word readback", rd, 32'hFEED_BEEF);
        host_op(1'b0, 1'b0, 11'd0, 4'hF, 32'h0, rd, n);
        chk("R11 register wait count", n, 6);
        chk("R11 register read data", rd, 0);
    endtask

    task automatic t_engine_local;
        logic [31:0] rd;
        logic es;
        int lat;
        int n;
        eng_op(2'b00, 1'b0, BASE + 64'd20, 32'h0, rd, es, lat);
        chk("R2 fetch data", rd, 32'h1122_CC44);
        chk("R2 fetch stays off bus", es, 0);
        chk("R2 fetch latency", lat, 1);
        eng_op(2'b01, 1'b0, BASE + 64'd8188, 32'h0, rd, es, lat);
        chk("R2 table-indirect data", rd, 32'hFEED_BEEF);
        chk("R2 table-indirect stays off bus", es, 0);
        eng_op(2'b10, 1'b1, BASE + 64'd8, 32'h0BAD_F00D, rd, es, lat);
        chk("R3 store stays off bus", es, 0);
        host_op(1'b1, 1'b0, 11'd2, 4'hF, 32'h0, rd, n);
        chk("R3 store landed in memory", rd, 32'h0BAD_F00D);
        eng_op(2'b10, 1'b0, BASE + 64'd8, 32'h0, rd, es, lat);
        chk("R3 load data", rd, 32'h0BAD_F00D);
    endtask

    task automatic t_engine_external;
        logic [31:0] rd;
        logic es;
        int lat;
        eng_op(2'b11, 1'b0, BASE + 64'd20, 32'h0, rd, es, lat);
        chk("R4 other kind goes out", es, 1);
        chk("R4 forwarded address", ext_addr_seen, BASE + 64'd20);
        chk("R4 data from bus", rd, (BASE[31:0] + 32'd20) ^ 32'hA5A5_A5A5);
        chk("R4 same-cycle ack", lat, 0);
        eng_op(2'b00, 1'b0, BASE + 64'h2000, 32'h0, rd, es, lat);
        chk("R5 next window is a miss", es, 1);
        eng_op(2'b00, 1'b0, BASE ^ (64'd1 << 40), 32'h0, rd, es, lat);
        chk("R5 high bit differs is a miss", es, 1);
        chk("R5 miss data from bus", rd, BASE[31:0] ^ 32'hA5A5_A5A5);
    endtask

    task automatic t_disable;
        logic [31:0] rd;
        logic es;
        int lat;
        @(negedge clk);
        en_wr = 1'b1; en_wdata = 1'b0;
        @(negedge clk);
        en_wr = 1'b0;
        #1;
        chk("R6 enable cleared", ram_en, 0);
        eng_op(2'b00, 1'b0, BASE + 64'd20, 32'h0, rd, es, lat);
        chk("R6 disabled fetch goes out", es, 1);
        chk("R6 disabled data from bus", rd, (BASE[31:0] + 32'd20) ^ 32'hA5A5_A5A5);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = 1'b1;
        @(negedge clk);
        en_wr = 1'b0;
        eng_op(2'b00, 1'b0, BASE + 64'd20, 32'h0, rd, es, lat);
        chk("R6 re-enabled fetch local", es, 0);
        chk("R6 re-enabled fetch data", rd, 32'h1122_CC44);
    endtask

    task automatic t_conflict;
        @(negedge clk);
        hst_sel = 1'b1; hst_ram = 1'b1; hst_we = 1'b0; hst_word = 11'd5; hst_be = 4'hF;
        @(negedge clk);
        hst_sel = 1'b0;
        @(negedge clk);
        @(negedge clk);
        eng_req = 1'b1; eng_kind = 2'b00; eng_we = 1'b0; eng_addr = BASE + 64'd8188;
        @(negedge clk);
        #1;
        chk("R12 engine served first", eng_ack, 1);
        chk("R12 engine data", eng_rdata, 32'hFEED_BEEF);
        chk("R12 host held back", hst_done, 0);
        eng_req = 1'b0;
        @(negedge clk);
        #1;
        chk("R12 host done one cycle late", hst_done, 1);
        chk("R12 host data", hst_rdata, 32'h1122_CC44);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base();
        t_host();
        t_engine_local();
        t_engine_external();
        t_disable();
        t_conflict();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule